// File: doc/BRIEF.md
# Isochronous Endpoint Buffer Error Detector

This block sits beside the single packet buffer of one isochronous endpoint. It follows whether that buffer currently holds a complete packet, and it judges each bus event against that state. In the receive direction the event is an incoming data packet. In the transmit direction the event is an IN token from the host.

When an event finds the buffer in the wrong state, the block reports it. A receive event that arrives while the buffer is still full, or that arrives corrupted, is dropped. An IN token that arrives before the buffer is ready is answered with a zero-length packet.

Two sticky flags separate the two kinds of fault:
- `ovrn_o` marks a buffer-level fault: a receive overrun or a transmit underrun.
- `crce_o` marks a packet-level fault: a CRC error or a bit-stuffing error.

After the single-cycle not-ready interrupt, software reads the flags to tell the two kinds apart. It then clears each flag with its own write-one-to-clear strobe. Packet decoding, the CRC computation and the buffer memory belong to other blocks.

Top module: `iso_err_det`

## Requirements
- R1: After reset, `ovrn_o`, `crce_o`, `nrdy_o`, `drop_o` and `zlp_o` are all 0, and the buffer is empty.
- R2: Receive direction (`dir_tx_i`=0): when `pkt_rx_i` arrives with `crc_err_i` or `stuff_err_i` high, then on the next cycle `crce_o` is 1, and `nrdy_o` and `drop_o` each pulse. The buffer state is not changed by that packet.
- R3: Receive direction: a clean packet that arrives while the buffer is full sets `ovrn_o`, pulses `nrdy_o` and `drop_o`, and leaves the buffer full.
- R4: Receive direction: a clean packet that arrives while the buffer is empty raises no flag and no pulse, and marks the buffer full. A `rd_done_i` pulse marks the buffer empty again.
- R5: Transmit direction (`dir_tx_i`=1): an `in_tok_i` that arrives while the buffer is empty sets `ovrn_o` and pulses `nrdy_o` and `zlp_o`. An `in_tok_i` that arrives while the buffer is full raises nothing and empties the buffer. A `wr_done_i` pulse marks the buffer full.
- R6: In the transmit direction `crce_o` is never set, and `pkt_rx_i`, `crc_err_i`, `stuff_err_i` and `rd_done_i` have no effect. In the receive direction `in_tok_i` and `wr_done_i` have no effect.
- R7: Both flags are sticky. `ovrn_clr_i` clears `ovrn_o` and `crce_clr_i` clears `crce_o` on the next cycle. If a set event and a clear for the same flag fall in one cycle, the flag ends up 1.
- R8: `nrdy_o` is a single-cycle pulse, with at most one per event. `drop_o` and `zlp_o` are high only together with `nrdy_o` and never both at once. Every `nrdy_o` pulse is accompanied by at least one flag set.
- R9: If a received packet is corrupted and the buffer is also full, only `crce_o` is set; `ovrn_o` keeps its previous value.
- R10: Every event is judged on the buffer state held at the start of its cycle. A done indication in that same cycle still takes effect. For example, an overrun together with `rd_done_i` leaves the buffer empty, and an underrun together with `wr_done_i` leaves it full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dir_tx_i | input | 1 | Direction select: 0 receive, 1 transmit |
| pkt_rx_i | input | 1 | Data packet received strobe |
| crc_err_i | input | 1 | CRC error on the packet in this cycle |
| stuff_err_i | input | 1 | Bit-stuffing error on the packet in this cycle |
| in_tok_i | input | 1 | IN token received strobe |
| rd_done_i | input | 1 | CPU has finished reading the buffer |
| wr_done_i | input | 1 | CPU has finished writing the buffer |
| ovrn_clr_i | input | 1 | Write-one-to-clear strobe for the overrun/underrun flag |
| crce_clr_i | input | 1 | Write-one-to-clear strobe for the packet error flag |
| ovrn_o | output | 1 | Sticky buffer overrun/underrun flag |
| crce_o | output | 1 | Sticky CRC or bit-stuffing error flag |
| nrdy_o | output | 1 | Not-ready interrupt pulse |
| drop_o | output | 1 | Discard-received-packet strobe |
| zlp_o | output | 1 | Send-zero-length-packet strobe |

## Verification
The hardest situations to reach from the ports are the ones where an event lands in the same cycle as a done indication or a flag clear. In those cycles the outcome depends on the buffer state, which is never visible directly.

The bench sweeps every combination of the six event and done inputs, from both a full and an empty buffer, in both directions. It builds each starting state through the normal done and packet inputs. After each case it reads back the resulting buffer state with a probe event in the same direction: a clean packet or an IN token, whose overrun flag reveals whether the buffer was full. Separate cases pair a flag-setting event with its own clear strobe to show that the set wins.

// File: rtl/iso_err_pkg.sv
package iso_err_pkg;
  localparam int unsigned N_FLAGS   = 2;
  localparam int unsigned FLAG_OVRN = 0;
  localparam int unsigned FLAG_CRCE = 1;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } xfer_dir_e;

  typedef struct packed {
    logic ovrn_set;
    logic crce_set;
    logic drop;
    logic zlp;
  } err_evt_t;
endpackage

// File: rtl/iso_err_classify.sv
module iso_err_classify
  import iso_err_pkg::*;
(
  input  xfer_dir_e dir_i,
  input  logic      full_i,
  input  logic      pkt_rx_i,
  input  logic      crc_err_i,
  input  logic      stuff_err_i,
  input  logic      in_tok_i,
  output err_evt_t  evt_o,
  output logic      accept_o,
  output logic      consume_o
);
  logic rx_ev, tx_ev, bad_pkt;

  always_comb begin
    rx_ev   = (dir_i == DIR_RX) && pkt_rx_i;
    tx_ev   = (dir_i == DIR_TX) && in_tok_i;
    bad_pkt = crc_err_i || stuff_err_i;

    evt_o          = '0;
    // packet error outranks overrun
    evt_o.crce_set = rx_ev && bad_pkt;
    evt_o.ovrn_set = (rx_ev && !bad_pkt && full_i) || (tx_ev && !full_i);
    evt_o.drop     = rx_ev && (bad_pkt || full_i);
    evt_o.zlp      = tx_ev && !full_i;

    accept_o  = rx_ev && !bad_pkt && !full_i;
    consume_o = tx_ev && full_i;
  end
endmodule

// File: rtl/iso_buf_track.sv
module iso_buf_track
  import iso_err_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  xfer_dir_e dir_i,
  input  logic      accept_i,
  input  logic      consume_i,
  input  logic      rd_done_i,
  input  logic      wr_done_i,
  output logic      full_o
);
  logic full_q, full_d;

  always_comb begin
    if (dir_i == DIR_RX) full_d = accept_i || (full_q && !rd_done_i);
    else                 full_d = wr_done_i || (full_q && !consume_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else         full_q <= full_d;
  end

  assign full_o = full_q;

  AST_ACCEPT_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> full_q); // R4
  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == DIR_TX && wr_done_i) |=> full_q); // R5
  AST_CONSUME_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !wr_done_i) |=> !full_q); // R5
endmodule

// File: rtl/iso_flag_bank.sv
module iso_flag_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;  // set wins over clear
      else if (clr_i[i]) q <= 1'b0;
    end
    assign q_o[i] = q;

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q); // R7
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q && !clr_i[i]) |=> q); // R7
    AST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !q); // R7
  end
endmodule

// File: rtl/iso_err_det.sv
module iso_err_det
  import iso_err_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_tx_i,
  input  logic pkt_rx_i,
  input  logic crc_err_i,
  input  logic stuff_err_i,
  input  logic in_tok_i,
  input  logic rd_done_i,
  input  logic wr_done_i,
  input  logic ovrn_clr_i,
  input  logic crce_clr_i,
  output logic ovrn_o,
  output logic crce_o,
  output logic nrdy_o,
  output logic drop_o,
  output logic zlp_o
);
  xfer_dir_e          dir;
  err_evt_t           evt;
  logic               full, accept, consume;
  logic [N_FLAGS-1:0] flag_set, flag_clr, flags;
  logic               nrdy_q, drop_q, zlp_q;

  assign dir = xfer_dir_e'(dir_tx_i);

  iso_err_classify i_classify (
    .dir_i      (dir),
    .full_i     (full),
    .pkt_rx_i   (pkt_rx_i),
    .crc_err_i  (crc_err_i),
    .stuff_err_i(stuff_err_i),
    .in_tok_i   (in_tok_i),
    .evt_o      (evt),
    .accept_o   (accept),
    .consume_o  (consume)
  );

  iso_buf_track i_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dir_i    (dir),
    .accept_i (accept),
    .consume_i(consume),
    .rd_done_i(rd_done_i),
    .wr_done_i(wr_done_i),
    .full_o   (full)
  );

  always_comb begin
    flag_set            = '0;
    flag_clr            = '0;
    flag_set[FLAG_OVRN] = evt.ovrn_set;
    flag_set[FLAG_CRCE] = evt.crce_set;
    flag_clr[FLAG_OVRN] = ovrn_clr_i;
    flag_clr[FLAG_CRCE] = crce_clr_i;
  end

  iso_flag_bank #(.N(N_FLAGS)) i_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nrdy_q <= 1'b0;
      drop_q <= 1'b0;
      zlp_q  <= 1'b0;
    end else begin
      nrdy_q <= evt.ovrn_set || evt.crce_set;
      drop_q <= evt.drop;
      zlp_q  <= evt.zlp;
    end
  end

  assign ovrn_o = flags[FLAG_OVRN];
  assign crce_o = flags[FLAG_CRCE];
  assign nrdy_o = nrdy_q;
  assign drop_o = drop_q;
  assign zlp_o  = zlp_q;

  AST_NO_CRCE_IN_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_tx_i && !crce_o) |=> !crce_o); // R6
  AST_CRC_OUTRANKS_OVRN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_tx_i && pkt_rx_i && (crc_err_i || stuff_err_i) && !ovrn_o) |=> !ovrn_o); // R9
  AST_STROBE_NEEDS_NRDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o || zlp_o) |-> nrdy_o); // R8
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drop_o && zlp_o)); // R8
  AST_NRDY_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nrdy_o |-> (ovrn_o || crce_o)); // R8
  AST_QUIET_NO_NRDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pkt_rx_i && !in_tok_i) |=> !nrdy_o); // R8
endmodule

// File: tb/test_iso_err_det.sv
module test_iso_err_det;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_tx = 0, pkt_rx = 0, crc_err = 0, stuff_err = 0, in_tok = 0;
  logic rd_done = 0, wr_done = 0, ovrn_clr = 0, crce_clr = 0;
  logic ovrn, crce, nrdy, drop, zlp;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  iso_err_det i_iso_err_det (
    .clk_i(clk), .rst_ni(rst_n), .dir_tx_i(dir_tx), .pkt_rx_i(pkt_rx),
    .crc_err_i(crc_err), .stuff_err_i(stuff_err), .in_tok_i(in_tok),
    .rd_done_i(rd_done), .wr_done_i(wr_done), .ovrn_clr_i(ovrn_clr),
    .crce_clr_i(crce_clr), .ovrn_o(ovrn), .crce_o(crce), .nrdy_o(nrdy),
    .drop_o(drop), .zlp_o(zlp)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    {pkt_rx, crc_err, stuff_err, in_tok, rd_done, wr_done, ovrn_clr, crce_clr} = '0;
  endtask

  // drive current inputs for one edge, then return to idle at the following negedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic setup(input bit d, input bit f);
    idle(); dir_tx = 0; rd_done = 1; step();
    dir_tx = d;
    if (f) begin
      if (d) wr_done = 1; else pkt_rx = 1;
      step();
    end
    ovrn_clr = 1; crce_clr = 1; step();
  endtask

  // returns the buffer-full state seen by a probe event in direction d
  task automatic probe(input bit d, output bit f);
    dir_tx = d;
    if (d) in_tok = 1; else pkt_rx = 1;
    step();
    f = d ? !ovrn : ovrn;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit pf;
    repeat (2) @(negedge clk);
    chk("R1", "ovrn", ovrn, 0); chk("R1", "crce", crce, 0);
    chk("R1", "nrdy", nrdy, 0); chk("R1", "drop", drop, 0);
    chk("R1", "zlp", zlp, 0);
    rst_n = 1;
    @(negedge clk);
    probe(0, pf);
    chk("R1", "empty after reset", pf, 0);

    for (int d = 0; d < 2; d++)
      for (int f = 0; f < 2; f++)
        for (int v = 0; v < 64; v++) begin
          bit p, c, s, t, rd, wr, bad, e_crce, e_ovrn, e_acc, e_nrdy, e_drop, e_zlp, e_full;
          string rq;
          {wr, rd, t, s, c, p} = v[5:0];
          bad    = c | s;
          e_crce = !d && p && bad;
          e_ovrn = d ? (t && !f) : (p && !bad && f);
          e_acc  = !d && p && !bad && !f;
          e_nrdy = e_crce | e_ovrn;
          e_drop = !d && e_nrdy;
          e_zlp  = d && e_nrdy;
          e_full = d ? (wr || (f && !t)) : (e_acc || (f && !rd));
          rq = d ? (e_ovrn ? "R5" : "R6") : (e_crce ? (f ? "R9" : "R2") : (e_ovrn ? "R3" : "R4"));
          setup(d[0], f[0]);
          {pkt_rx, crc_err, stuff_err, in_tok, rd_done, wr_done} = {p, c, s, t, rd, wr};
          step();
          chk(rq, "ovrn", ovrn, e_ovrn);
          chk(d ? "R6" : rq, "crce", crce, e_crce);
          chk(rq, "nrdy", nrdy, e_nrdy);
          chk("R8", "drop", drop, e_drop);
          chk("R8", "zlp", zlp, e_zlp);
          ovrn_clr = 1; crce_clr = 1; step();
          chk("R8", "nrdy pulse ends", nrdy, 0);
          chk("R7", "flags cleared", {ovrn, crce}, 0);
          probe(d[0], pf);
          chk((rd || wr) ? "R10" : rq, "buffer state", pf, e_full);
        end

    // R7: set and clear in the same cycle, set wins; clears are per flag
    setup(0, 1);
    pkt_rx = 1; ovrn_clr = 1; step();
    chk("R7", "ovrn set beats clear", ovrn, 1);
    pkt_rx = 1; crc_err = 1; crce_clr = 1; step();
    chk("R7", "crce set beats clear", crce, 1);
    chk("R9", "ovrn held on crc", ovrn, 1);
    repeat (3) step();
    chk("R7", "ovrn sticky", ovrn, 1);
    crce_clr = 1; step();
    chk("R7", "crce cleared", crce, 0);
    chk("R7", "ovrn untouched by crce clear", ovrn, 1);
    ovrn_clr = 1; step();
    chk("R7", "ovrn cleared", ovrn, 0);

    // R8: back-to-back underruns give one pulse each
    setup(1, 0);
    in_tok = 1; @(negedge clk);
    chk("R8", "first pulse", nrdy, 1);
    @(negedge clk); idle();
    chk("R8", "second pulse", nrdy, 1);
    step();
    chk("R8", "pulses end", nrdy, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule